// File: doc/BRIEF.md
# Transmit Staging Register with Ready Flag

This block holds one character between a CPU write port and a transmit shift register. The CPU writes a character when the ready flag is high. The block keeps that character until the shifter reports that it is idle, then passes it across with a one-cycle load strobe. The serialiser itself lies outside this block.

The ready flag follows the transmitter's enable state. Enabling the transmitter raises ready with an empty stage. Disabling it lowers ready and discards any character that has not yet been passed on, so a character written while the transmitter is off never reaches the line. The flag is driven on three outputs: the main ready output, the channel status copy and the interrupt status copy.

Top module: `tx_stage_top`

## Requirements
- R1: After reset the transmitter is disabled, so ready is 0 and the load strobe is 0.
- R2: Ready is 1 exactly when the transmitter is enabled and the stage holds no character.
- R3: A write (`cpu_wr`=1) while ready is 1 stores `cpu_data` and drives ready to 0 from the next cycle.
- R4: While a character is held, the transmitter is enabled, `shift_idle` is 1 and no disable command is present, `load_stb` is 1 in that same cycle with `load_data` equal to the stored character. Ready returns to 1 in the next cycle.
- R5: While `shift_idle` is 0, `load_stb` stays 0 and the held character is kept.
- R6: A pulse on `tx_enable` raises ready in the next cycle. A pulse on `tx_disable` drops ready in the next cycle and discards the held character, which is not loaded even after the transmitter is enabled again.
- R7: When `tx_enable` and `tx_disable` are both 1 in the same cycle, the disable takes effect.
- R8: A write while ready is 0 is ignored. It leaves the held character unchanged, and a write made while the transmitter is disabled is never loaded.
- R9: `stat_ready` and `irq_ready` always equal `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | CPU write strobe for the staging register |
| cpu_data | input | DATA_W | Character written by the CPU |
| tx_enable | input | 1 | Enable-transmitter command pulse |
| tx_disable | input | 1 | Disable-transmitter command pulse |
| shift_idle | input | 1 | Shift register can take a new character |
| load_stb | output | 1 | Moves the held character into the shifter |
| load_data | output | DATA_W | Held character |
| ready | output | 1 | Staging register may be written |
| stat_ready | output | 1 | Channel status copy of ready |
| irq_ready | output | 1 | Interrupt status copy of ready |

## Verification
The bench builds the block with the default DATA_W of 8. At that width the bench can use distinct bit patterns such as 0xA5, 0x3C and 0xFF, which tell a kept character apart from an overwritten one. Short busy windows on `shift_idle` and command pulses timed against a held character reach the discard case and the case where enable and disable arrive in the same cycle.

// File: rtl/tx_stage_pkg.sv
package tx_stage_pkg;
    typedef struct packed {
        logic full;
    } hold_flags_t;
endpackage

// File: rtl/tx_stage_enable.sv
module tx_stage_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic en_cmd,
    input  logic dis_cmd,
    output logic enabled
);
    logic en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (en_cmd)  en_d = 1'b1;
        if (dis_cmd) en_d = 1'b0;   // disable has priority
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign enabled = en_q;
endmodule

// File: rtl/tx_stage_hold.sv
module tx_stage_hold
    import tx_stage_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enabled,
    input  logic              dis_cmd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              idle,
    output logic              load,
    output logic [DATA_W-1:0] data,
    output logic              rdy
);
    typedef struct packed {
        hold_flags_t       flags;
        logic [DATA_W-1:0] chr;
    } hold_state_t;

    hold_state_t st_d, st_q;
    logic        accept;

    always_comb begin
        st_d   = st_q;
        rdy    = enabled && !st_q.flags.full;
        accept = wr && rdy;
        load   = st_q.flags.full && enabled && idle && !dis_cmd;
        if (accept) begin
            st_d.flags.full = 1'b1;
            st_d.chr        = wr_data;
        end
        if (load)    st_d.flags.full = 1'b0;
        if (dis_cmd) st_d.flags.full = 1'b0;  // held character dropped
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data = st_q.chr;
endmodule

// File: rtl/tx_stage_top.sv
module tx_stage_top #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              tx_enable,
    input  logic              tx_disable,
    input  logic              shift_idle,
    output logic              load_stb,
    output logic [DATA_W-1:0] load_data,
    output logic              ready,
    output logic              stat_ready,
    output logic              irq_ready
);
    logic enabled;

    tx_stage_enable u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_cmd  (tx_enable),
        .dis_cmd (tx_disable),
        .enabled (enabled)
    );

    tx_stage_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .enabled (enabled),
        .dis_cmd (tx_disable),
        .wr      (cpu_wr),
        .wr_data (cpu_data),
        .idle    (shift_idle),
        .load    (load_stb),
        .data    (load_data),
        .rdy     (ready)
    );

    assign stat_ready = ready;
    assign irq_ready  = ready;
endmodule

// File: rtl/tx_stage_checker.sv
module tx_stage_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr,
    input logic              tx_enable,
    input logic              tx_disable,
    input logic              shift_idle,
    input logic              load_stb,
    input logic [DATA_W-1:0] load_data,
    input logic              ready,
    input logic              stat_ready,
    input logic              irq_ready
);
    a_r3_write_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cpu_wr && !tx_disable) |=> !ready);

    a_r4_load_restores_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && !tx_disable) |=> ready);

    a_r5_load_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> (shift_idle && !ready));

    a_r6_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
        tx_disable |=> (!ready && !load_stb));

    a_r8_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && cpu_wr) |=> $stable(load_data));

    always_comb begin
        if (rst_n) begin
            a_r9_mirrors: assert (stat_ready == ready && irq_ready == ready);
        end
    end
endmodule

bind tx_stage_top tx_stage_checker #(.DATA_W(DATA_W)) u_checker (.*);

// File: tb/test_tx_stage_top.sv
module test_tx_stage_top;
    localparam int W = 8;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_wr = 1'b0, tx_enable = 1'b0, tx_disable = 1'b0, shift_idle = 1'b0;
    logic [W-1:0] cpu_data = '0;
    logic load_stb, ready, stat_ready, irq_ready;
    logic [W-1:0] load_data;
    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    tx_stage_top #(.DATA_W(W)) i_tx_stage_top (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
        cpu_wr = 0; tx_enable = 0; tx_disable = 0;
    endtask

    task automatic t_reset();
        #1;
        chk("R1 ready", ready, 0);
        chk("R1 load", load_stb, 0);
        chk("R9 mirrors", {stat_ready, irq_ready}, 2'b00);
    endtask

    task automatic t_enable();
        tx_enable = 1; step(); #1;
        chk("R6 enable ready", ready, 1);
        chk("R2 ready empty", ready, 1);
        chk("R9 mirrors", {stat_ready, irq_ready}, 2'b11);
    endtask

    task automatic t_write_transfer();
        shift_idle = 0; cpu_wr = 1; cpu_data = 8'hA5; step(); #1;
        chk("R3 ready cleared", ready, 0);
        chk("R9 mirrors", {stat_ready, irq_ready}, 2'b00);
        for (int i = 0; i < 3; i++) begin
            chk("R5 no load busy", load_stb, 0);
            step(); #1;
        end
        shift_idle = 1; #1;
        chk("R4 load strobe", load_stb, 1);
        chk("R4 load data", load_data, 8'hA5);
        step(); shift_idle = 0; #1;
        chk("R4 ready back", ready, 1);
        chk("R4 single strobe", load_stb, 0);
    endtask

    task automatic t_ignored();
        cpu_wr = 1; cpu_data = 8'h3C; step();
        cpu_wr = 1; cpu_data = 8'hFF; step();
        shift_idle = 1; #1;
        chk("R8 ignored write", load_data, 8'h3C);
        chk("R4 load", load_stb, 1);
        step(); shift_idle = 0; #1;
    endtask

    task automatic t_disable_discard();
        cpu_wr = 1; cpu_data = 8'h11; step();
        tx_disable = 1; step(); #1;
        chk("R6 disable ready", ready, 0);
        shift_idle = 1; tx_enable = 1; #1;
        chk("R6 no load disabled", load_stb, 0);
        step(); #1;
        chk("R6 discarded", load_stb, 0);
        chk("R6 re-enable ready", ready, 1);
        shift_idle = 0;
    endtask

    task automatic t_write_disabled();
        tx_disable = 1; step();
        shift_idle = 1; cpu_wr = 1; cpu_data = 8'h77; #1;
        chk("R8 disabled ready", ready, 0);
        step(); #1;
        chk("R8 disabled no load", load_stb, 0);
        tx_enable = 1; step(); #1;
        chk("R8 never loaded", load_stb, 0);
        chk("R2 ready empty", ready, 1);
        shift_idle = 0;
    endtask

    task automatic t_both();
        tx_enable = 1; tx_disable = 1; step(); #1;
        chk("R7 disable wins", ready, 0);
        tx_enable = 1; step(); #1;
        chk("R2 ready", ready, 1);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk); t_reset();
        @(negedge clk); rst_n = 1; @(negedge clk);
        t_reset();
        t_enable();
        t_write_transfer();
        t_ignored();
        t_disable_discard();
        t_write_disabled();
        t_both();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule